// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures an external signal in one of two ways. In frequency mode it counts rising edges of the input during a gate window of 4, 8, 32 or 64 ms. In period mode it counts system clocks across one or two full input cycles. The time base is a one-cycle-wide tick that arrives once per millisecond. A start pulse latches the configuration and begins a settling wait. The gate then opens. When the result is ready, the block raises an end flag. That flag is meant to be routed to a shared status pin.

The settling wait depends on the gate code and on a fast-wait control bit. With the bit clear, codes 00 and 01 wait 4 whole ticks (3 to 4 ms) and codes 10 and 11 wait 8 ticks (7 to 8 ms). With the bit set, every code waits 2 ticks (1 to 2 ms). The input passes through a two-flop synchroniser and a rising-edge detector. While the enable is low and the fast-wait bit is clear, the synchroniser is held at zero so the input is blocked. With the fast-wait bit set, the synchroniser keeps running while the block is disabled.

The controller has six states:
- IDLE: waits for start.
- SETTLE: times the wait.
- GATE: frequency window.
- ARM: period mode, waiting for the first rising edge.
- TIME: period mode, counting clocks.
- DONE: result held.

Its transitions are:
- IDLE→SETTLE and DONE→SETTLE on an accepted start.
- SETTLE→GATE or SETTLE→ARM on the final wait tick.
- GATE→DONE on the final gate tick.
- ARM→TIME on the first edge.
- TIME→DONE on the closing edge.
- any state→IDLE while the enable is low.

Top module: `gfc_meter`

## Requirements
- R1: After reset, `count` is 0 and `end_flag` is 0.
- R2: In frequency mode (`period_mode`=0), `gate_sel` 0,1,2,3 opens a gate of 4, 8, 32, 64 ticks. `count` equals the number of input rising edges inside that window.
- R3: With `wait_fast`=0, the wait lasts 4 ticks for `gate_sel` 0/1 and 8 ticks for 2/3. In frequency mode, `end_flag` rises one clock after tick number wait+gate following the start.
- R4: With `wait_fast`=1, the wait lasts 2 ticks for every `gate_sel` code.
- R5: In period mode (`period_mode`=1), `gate_sel` 0/1 time one input cycle and 2/3 time two. `count` equals the clocks from the first qualifying rising edge to the closing one.
- R6: `count` saturates at 2^CNT_W-1 and never wraps.
- R7: `end_flag` and `count` hold in DONE until an accepted start. The start clears both on the next clock.
- R8: While `cnt_en` is 0, `count` and `end_flag` are forced to 0 and start is ignored.
- R9: `period_mode`, `gate_sel` and `wait_fast` are latched at start. Changes during a measurement have no effect.
- R10: A start pulse during SETTLE, GATE, ARM or TIME is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| meas_in | input | 1 | Asynchronous signal under measurement |
| cnt_en | input | 1 | Counter enable; low holds the block cleared |
| start | input | 1 | Start pulse |
| period_mode | input | 1 | 0 = frequency, 1 = period |
| gate_sel | input | 2 | Gate time / cycle count code |
| wait_fast | input | 1 | Shortened wait; keeps input live while disabled |
| count | output | CNT_W | Measurement result |
| end_flag | output | 1 | Measurement complete, held until restart |

## Verification
The input is a periodic wave whose period divides the tick spacing. Every gate window of the correct length therefore holds an exact number of edges. A window that is one clock too long or too short, or that misses the closing-tick edge, changes the count by one edge. The wait is checked by counting ticks between start and the end flag. A design that ignored the fast-wait bit, or that keyed the wait on the wrong code bit, reports the wrong tick total. Four further cases are checked:
- Saturation: a design that wraps shows a small count instead of the maximum.
- Configuration changed mid-run: a design that reads the live inputs stretches the gate.
- Start pulsed mid-run: a design that restarts adds ticks.
- Disable: a design that obeys start while disabled raises the flag.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

    localparam int TICK_W = 7;
    localparam int CYC_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GATE,
        ST_ARM,
        ST_TIME,
        ST_DONE
    } gfc_state_e;

    typedef struct packed {
        logic       period;
        logic [1:0] sel;
        logic       fast;
    } gfc_cfg_t;

    function automatic logic [TICK_W-1:0] settle_ticks(input logic [1:0] sel, input logic fast);
        if (fast)
            return TICK_W'(2);
        else if (sel[1])
            return TICK_W'(8);
        else
            return TICK_W'(4);
    endfunction

    function automatic logic [TICK_W-1:0] gate_ticks(input logic [1:0] sel);
        logic [TICK_W-1:0] g;
        unique case (sel)
            2'd0: g = TICK_W'(4);
            2'd1: g = TICK_W'(8);
            2'd2: g = TICK_W'(32);
            2'd3: g = TICK_W'(64);
            default: g = TICK_W'(4);
        endcase
        return g;
    endfunction

    function automatic logic [CYC_W-1:0] period_cycles(input logic [1:0] sel);
        return sel[1] ? CYC_W'(2) : CYC_W'(1);
    endfunction

endpackage

// File: rtl/gfc_edge_sync.sv
module gfc_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic block,
    output logic rise
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (block)
            shreg <= '0;
        else
            shreg <= {shreg[SH_W-2:0], async_in};
    end

    assign rise = shreg[SYNC_N-1] & ~shreg[SYNC_N];

endmodule

// File: rtl/gfc_sat_counter.sv
module gfc_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= '0;
        else if (clr)
            value <= '0;
        else if (inc && value != TOP)
            value <= value + 1'b1;
    end

endmodule

// File: rtl/gfc_seq.sv
module gfc_seq
    import gfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     start,
    input  logic     tick,
    input  logic     rise,
    input  gfc_cfg_t cfg_in,
    output logic     cnt_clr,
    output logic     cnt_inc,
    output logic     done
);
    gfc_state_e        state_q, state_d;
    gfc_cfg_t          cfg_q;
    logic [TICK_W-1:0] tcnt_q;
    logic [CYC_W-1:0]  ecnt_q;
    logic              take;
    logic [TICK_W-1:0] wait_lim, gate_lim;
    logic [CYC_W-1:0]  cyc_lim;

    assign take     = en & start & (state_q == ST_IDLE || state_q == ST_DONE);
    assign wait_lim = settle_ticks(cfg_q.sel, cfg_q.fast);
    assign gate_lim = gate_ticks(cfg_q.sel);
    assign cyc_lim  = period_cycles(cfg_q.sel);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = ST_SETTLE;
            ST_SETTLE: if (tick && tcnt_q == wait_lim - 1'b1)
                           state_d = cfg_q.period ? ST_ARM : ST_GATE;
            ST_GATE:   if (tick && tcnt_q == gate_lim - 1'b1) state_d = ST_DONE;
            ST_ARM:    if (rise) state_d = ST_TIME;
            ST_TIME:   if (rise && ecnt_q == cyc_lim - 1'b1) state_d = ST_DONE;
            ST_DONE:   if (take) state_d = ST_SETTLE;
            default:   state_d = ST_IDLE;
        endcase
        if (!en)
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // tick / edge counters and configuration latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            tcnt_q <= '0;
            ecnt_q <= '0;
        end else begin
            if (take)
                cfg_q <= cfg_in;
            if (state_d != state_q)
                tcnt_q <= '0;
            else if (tick && (state_q == ST_SETTLE || state_q == ST_GATE))
                tcnt_q <= tcnt_q + 1'b1;
            if (state_d != state_q)
                ecnt_q <= '0;
            else if (rise && state_q == ST_TIME)
                ecnt_q <= ecnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cnt_clr = take | ~en;
        cnt_inc = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_GATE: cnt_inc = rise;
            ST_ARM:  if (rise) cnt_clr = 1'b1;
            ST_TIME: cnt_inc = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/gfc_meter.sv
module gfc_meter
    import gfc_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             meas_in,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             period_mode,
    input  logic [1:0]       gate_sel,
    input  logic             wait_fast,
    output logic [CNT_W-1:0] count,
    output logic             end_flag
);
    logic     rise, clr, inc, block;
    gfc_cfg_t cfg;

    assign block = ~cnt_en & ~wait_fast;
    assign cfg   = '{period: period_mode, sel: gate_sel, fast: wait_fast};

    gfc_edge_sync #(.SYNC_N(SYNC_N)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(meas_in), .block(block), .rise(rise)
    );

    gfc_seq seq_i (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .start(start), .tick(ms_tick),
        .rise(rise), .cfg_in(cfg), .cnt_clr(clr), .cnt_inc(inc), .done(end_flag)
    );

    gfc_sat_counter #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .value(count)
    );

endmodule

// File: rtl/gfc_meter_chk.sv
module gfc_meter_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             start,
    input logic [CNT_W-1:0] count,
    input logic             end_flag
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (count == '0 && !end_flag)); // R1

    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (count == '0 && !end_flag)); // R8

    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && cnt_en && !start) |=> (end_flag && $stable(count))); // R7

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && cnt_en && start) |=> (!end_flag && count == '0)); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !start && !end_flag) |=> (count >= $past(count))); // R6

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !start && count == TOP) |=> (count == TOP)); // R6

endmodule

bind gfc_meter gfc_meter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start),
    .count(count), .end_flag(end_flag)
);

// File: tb/gfc_meter_tb_top.sv
`timescale 1ns/1ps
module gfc_meter_tb_top;
    localparam int CW = 10;
    localparam int TP = 40;   // clocks per ms tick

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0;
    logic          meas_in = 1'b0;
    logic          cnt_en = 1'b0;
    logic          start = 1'b0;
    logic          period_mode = 1'b0;
    logic [1:0]    gate_sel = 2'd0;
    logic          wait_fast = 1'b0;
    logic [CW-1:0] count;
    logic          end_flag;

    int n_checks = 0;
    int n_fail   = 0;
    int hi_len = 4, lo_len = 4;
    logic in_run = 1'b0;

    always #2.5 clk = ~clk;

    gfc_meter #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .meas_in(meas_in),
        .cnt_en(cnt_en), .start(start), .period_mode(period_mode),
        .gate_sel(gate_sel), .wait_fast(wait_fast), .count(count), .end_flag(end_flag)
    );

    // tick generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == TP - 1) ? 0 : ph + 1;
            ms_tick = (ph == 0);
        end
    end

    // input wave generator
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (!in_run) begin
                meas_in = 1'b0;
                ph = 0;
            end else begin
                ph = ph + 1;
                if (ph >= hi_len + lo_len) ph = 0;
                meas_in = (ph < hi_len);
            end
        end
    end

    function automatic int exp_gate(input int sel);
        case (sel)
            0: return 4;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int exp_wait(input int sel, input int fast);
        if (fast != 0) return 2;
        return (sel >= 2) ? 8 : 4;
    endfunction

    function automatic int exp_cyc(input int sel);
        return (sel >= 2) ? 2 : 1;
    endfunction

    task automatic report;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_wave(input int hi, input int lo);
        @(posedge clk);
        in_run = 1'b0;
        repeat (3) @(posedge clk);
        hi_len = hi;
        lo_len = lo;
        in_run = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // poke_kind: 0 none, 1 flip gate_sel, 2 pulse start
    task automatic run_meas(input logic pm, input int sel, input int fast,
                            input int poke_at, input int poke_kind, output int ticks);
        int cyc = 0;
        ticks = 0;
        @(negedge clk);
        period_mode = pm;
        gate_sel = 2'(sel);
        wait_fast = fast[0];
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        while (cyc < 6000) begin
            @(posedge clk);
            if (ms_tick) ticks++;
            @(negedge clk);
            cyc++;
            if (poke_kind == 1 && cyc == poke_at) gate_sel = ~gate_sel;
            if (poke_kind == 2 && cyc == poke_at) start = 1'b1;
            if (poke_kind == 2 && cyc == poke_at + 1) start = 1'b0;
            if (end_flag) break;
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        int t;
        int periods[5] = '{4, 8, 10, 20, 40};
        void'($urandom(32'h5EED_0042));

        repeat (5) @(negedge clk);
        chk("R1 count after reset", int'(count), 0);
        chk("R1 end_flag after reset", int'(end_flag), 0);
        rst_n = 1'b1;
        cnt_en = 1'b1;
        set_wave(4, 4);

        // directed frequency: every code, both wait settings (R2 R3 R4)
        for (int s = 0; s < 4; s++) begin
            for (int f = 0; f < 2; f++) begin
                run_meas(1'b0, s, f, -1, 0, t);
                chk("R2 freq count", int'(count), exp_gate(s) * TP / 8);
                chk(f ? "R4 fast wait ticks" : "R3 wait ticks", t, exp_wait(s, f) + exp_gate(s));
                chk("R2 end_flag", int'(end_flag), 1);
            end
        end

        // random frequency runs (R2 R3 R4)
        for (int i = 0; i < 8; i++) begin
            int p, s, f, h;
            p = periods[$urandom % 5];
            h = 1 + ($urandom % (p - 1));
            s = $urandom % 4;
            f = $urandom % 2;
            set_wave(h, p - h);
            run_meas(1'b0, s, f, -1, 0, t);
            chk("R2 random freq count", int'(count), exp_gate(s) * TP / p);
            chk("R3 R4 random wait ticks", t, exp_wait(s, f) + exp_gate(s));
        end

        // period mode directed (R5)
        set_wave(9, 8);
        run_meas(1'b1, 0, 0, -1, 0, t);
        chk("R5 one cycle", int'(count), 17);
        run_meas(1'b1, 3, 1, -1, 0, t);
        chk("R5 two cycles", int'(count), 34);

        // period mode random (R5)
        for (int i = 0; i < 6; i++) begin
            int p, s, h;
            p = 6 + ($urandom % 195);
            h = 1 + ($urandom % (p - 1));
            s = $urandom % 4;
            set_wave(h, p - h);
            run_meas(1'b1, s, $urandom % 2, -1, 0, t);
            chk("R5 random period count", int'(count), exp_cyc(s) * p);
        end

        // saturation (R6)
        set_wave(300, 300);
        run_meas(1'b1, 2, 1, -1, 0, t);
        chk("R6 saturated count", int'(count), (1 << CW) - 1);

        // hold and restart (R7)
        set_wave(5, 5);
        run_meas(1'b0, 0, 0, -1, 0, t);
        repeat (150) @(negedge clk);
        chk("R7 end held", int'(end_flag), 1);
        chk("R7 count held", int'(count), 4 * TP / 10);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 restart clears end", int'(end_flag), 0);
        chk("R7 restart clears count", int'(count), 0);
        repeat (400) @(negedge clk);

        // disable (R8)
        cnt_en = 1'b0;
        @(negedge clk);
        chk("R8 disable clears count", int'(count), 0);
        chk("R8 disable clears end", int'(end_flag), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3000) @(negedge clk);
        chk("R8 start ignored end", int'(end_flag), 0);
        chk("R8 start ignored count", int'(count), 0);
        cnt_en = 1'b1;
        repeat (5) @(negedge clk);
        run_meas(1'b0, 1, 1, -1, 0, t);
        chk("R8 run after enable", int'(count), 8 * TP / 10);

        // configuration latched at start (R9)
        run_meas(1'b0, 0, 0, 50, 1, t);
        chk("R9 latched gate ticks", t, 8);
        chk("R9 latched gate count", int'(count), 4 * TP / 10);

        // start ignored mid-run (R10)
        run_meas(1'b0, 1, 0, 300, 2, t);
        chk("R10 restart ignored ticks", t, 12);
        chk("R10 restart ignored count", int'(count), 8 * TP / 10);

        report();
    end

endmodule